// File: doc/BRIEF.md
# Signed Current Averaging and Charge Integration Core

This block turns a stream of signed current-sense samples into two host-visible words: an averaged current reading and a running signed charge count. Every sample is corrected by a programmable signed offset before it reaches either path. Positive values stand for charge flowing into the cell and negative values for discharge. A strobe marks each valid sample. A millisecond tick provides the time base, so the reading is refreshed at a fixed cadence of `MS_PER_UPD` ticks, 88 ms by default.

At the end of each window, the corrected samples of that window are summed and divided by `2**AVG_LOG2` (128 by default) with floor rounding. The result is clamped to a 13-bit signed range and published left-justified in a 16-bit word. The same average is added to a fractional residue. The 16-bit charge counter moves by one whenever a whole unit of `RES_DIV` averaged counts has built up in that residue, and it saturates at its limits. A byte-wide port lets a host read both words as high/low byte pairs with a coherent snapshot, and overwrite the charge counter atomically.

Top module: `batt_current_meter`

## Requirements
- R1: Each sample (13-bit two's complement) has the 8-bit two's-complement `bias` subtracted from it before it is averaged or integrated. A bias of 0 leaves samples unchanged.
- R2: `cur_word` changes only on the cycle after the `MS_PER_UPD`-th `ms_tick` of a window. It then takes floor(sum of the window's corrected samples / 2**AVG_LOG2), and otherwise it holds its value.
- R3: `cur_word[15:3]` holds the 13-bit two's-complement average and `cur_word[2:0]` is always 0.
- R4: An average above +4095 is reported as +4095 (`cur_word` = 0x7FF8). An average below -4096 is reported as -4096 (0x8000).
- R5: One cycle after each current update, the average is added to a residue. When the residue reaches +RES_DIV, the residue drops by RES_DIV and `acc_word` increments. When it reaches -RES_DIV, the residue rises by RES_DIV and `acc_word` decrements. `acc_word` never moves by more than one per cycle.
- R6: `acc_word` (16-bit two's complement) saturates at 0x7FFF and 0x8000 instead of wrapping.
- R7: A host write to address 2 stages the high byte. A write to address 3 loads {staged, data} into `acc_word` on the next edge, clears the residue, and takes priority over any integration on that edge. Writes to addresses 0 and 1 are ignored.
- R8: A read is returned on `host_rdata` one cycle later. Address 0 returns the live high byte of `cur_word`, and address 2 returns the live high byte of `acc_word`. Either high-byte read also captures that word's low byte. Address 1 and address 3 return the captured low byte. `host_rdata` holds between reads.
- R9: After reset, `cur_word`, `acc_word`, the residue and `host_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W (13) | Signed current sample |
| bias | input | BIAS_W (8) | Signed offset subtracted from each sample |
| ms_tick | input | 1 | One-millisecond time-base pulse |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request |
| host_addr | input | 2 | 0 current high, 1 current low, 2 charge high, 3 charge low |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| cur_word | output | 16 | Averaged current, left-justified |
| acc_word | output | 16 | Signed charge counter |

## Verification
Several properties are checked on every cycle:
- the current word holds between window ends;
- the charge counter steps by at most one and never wraps at its limits;
- the residue stays inside plus or minus RES_DIV;
- a host load lands exactly and clears the residue;
- low-byte reads return the captured snapshot.

The bench scenarios are needed for the arithmetic that spans a whole window: the bias subtraction, floor rounding of negative sums, clamping at both ends, and the slow carry of residue into the counter. Snapshot coherence across a changing counter also needs a scenario, because the low-byte read comes many cycles after the high-byte read.

// File: rtl/bcm_pkg.sv
// Shared types for the current averaging and charge integration core.
package bcm_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    // Host port address map.
    typedef enum logic [1:0] {
        RA_CUR_HI = 2'd0,
        RA_CUR_LO = 2'd1,
        RA_ACC_HI = 2'd2,
        RA_ACC_LO = 2'd3
    } reg_addr_e;

    // One averaged result handed from the window stage to the integrator.
    typedef struct packed {
        logic                     stb;
        logic signed [WORD_W-1:0] val;
    } avg_msg_t;
endpackage

// File: rtl/bcm_avg_window.sv
// Averaging window: subtracts the bias from every valid sample and sums the
// corrected samples over MS_PER_UPD ms ticks. At the window end it divides
// the sum by 2**AVG_LOG2 (floor), clamps the result to SAMPLE_W signed bits,
// publishes it left-justified in a 16-bit word and strobes it to the
// integrator. Assumes at most 2**(AVG_LOG2+1) samples arrive per window.
module bcm_avg_window
    import bcm_pkg::*;
#(
    parameter int SAMPLE_W   = 13,
    parameter int BIAS_W     = 8,
    parameter int AVG_LOG2   = 7,
    parameter int MS_PER_UPD = 88
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [BIAS_W-1:0]   bias,
    input  logic                ms_tick,
    output logic [WORD_W-1:0]   cur_word,
    output avg_msg_t            avg_o
);
    localparam int CORR_W = ((SAMPLE_W > BIAS_W) ? SAMPLE_W : BIAS_W) + 1;
    localparam int SUM_W  = CORR_W + AVG_LOG2 + 1;
    localparam int LPAD   = WORD_W - SAMPLE_W;
    localparam int CNT_W  = (MS_PER_UPD > 1) ? $clog2(MS_PER_UPD) : 1;
    localparam logic signed [SUM_W-1:0] LIM_HI = SUM_W'((2 ** (SAMPLE_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LIM_LO = -SUM_W'(2 ** (SAMPLE_W - 1));

    logic signed [CORR_W-1:0]   corr;
    logic signed [SUM_W-1:0]    sum_q, sum_next, avg_full;
    logic signed [SAMPLE_W-1:0] avg_sat;
    logic                       close;

    // Offset-corrected sample, both operands sign-extended.
    always_comb begin
        corr = $signed({{(CORR_W-SAMPLE_W){smp_data[SAMPLE_W-1]}}, smp_data})
             - $signed({{(CORR_W-BIAS_W){bias[BIAS_W-1]}}, bias});
    end

    // Window length: a tick counter, or every tick when the window is one ms.
    generate
        if (MS_PER_UPD > 1) begin : g_cnt
            logic [CNT_W-1:0] ms_cnt;
            assign close = ms_tick && (ms_cnt == CNT_W'(MS_PER_UPD - 1));
            // Count ticks within the current window.
            always_ff @(posedge clk) begin
                if (!rst_n)       ms_cnt <= '0;
                else if (close)   ms_cnt <= '0;
                else if (ms_tick) ms_cnt <= ms_cnt + 1'b1;
            end
        end else begin : g_nocnt
            assign close = ms_tick;
        end
    endgenerate

    // Running sum including this cycle's sample, its floor average and clamp.
    always_comb begin
        sum_next = sum_q + (smp_valid ? SUM_W'(corr) : '0);
        avg_full = sum_next >>> AVG_LOG2;
        if (avg_full > LIM_HI)      avg_sat = LIM_HI[SAMPLE_W-1:0];
        else if (avg_full < LIM_LO) avg_sat = LIM_LO[SAMPLE_W-1:0];
        else                        avg_sat = avg_full[SAMPLE_W-1:0];
    end

    // Accumulate the window, then publish and restart it at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q     <= '0;
            cur_word  <= '0;
            avg_o.stb <= 1'b0;
            avg_o.val <= '0;
        end else begin
            avg_o.stb <= close;
            if (close) begin
                sum_q     <= '0;
                cur_word  <= {avg_sat, {LPAD{1'b0}}};
                avg_o.val <= {{LPAD{avg_sat[SAMPLE_W-1]}}, avg_sat};
            end else begin
                sum_q <= sum_next;
            end
        end
    end

    AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !close |=> $stable(cur_word)); // R2
    AST_AVG_MATCHES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        avg_o.stb |-> (avg_o.val[SAMPLE_W-1:0] == cur_word[WORD_W-1:LPAD])); // R3
    AST_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (close && (avg_full > LIM_HI)) |=> (cur_word == {1'b0, {(WORD_W-LPAD-1){1'b1}}, {LPAD{1'b0}}})); // R4
endmodule

// File: rtl/bcm_coulomb.sv
// Charge integrator: adds each averaged current to a signed fractional
// residue and moves the signed charge counter by one whole unit per RES_DIV
// of residue, saturating at the counter limits. A host load replaces the
// counter, clears the residue and wins over an integration on the same edge.
// Assumes |average| < RES_DIV, so at most one carry per update.
module bcm_coulomb
    import bcm_pkg::*;
#(
    parameter int ACC_W   = 16,
    parameter int RES_DIV = 16364
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  avg_msg_t                avg_i,
    input  logic                    load,
    input  logic [ACC_W-1:0]        load_word,
    output logic signed [ACC_W-1:0] acc_o
);
    localparam int RES_W = $clog2(RES_DIV + 2 ** (WORD_W - 1)) + 2;
    localparam logic signed [RES_W-1:0] DIV_P = RES_W'(RES_DIV);
    localparam logic signed [RES_W-1:0] DIV_N = -RES_W'(RES_DIV);
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [RES_W-1:0] res_q, res_sum;
    logic                    carry_up, carry_dn;

    // Residue after adding this update's average, and the carry decision.
    always_comb begin
        res_sum  = res_q + $signed({{(RES_W-WORD_W){avg_i.val[WORD_W-1]}}, avg_i.val});
        carry_up = (res_sum >= DIV_P);
        carry_dn = (res_sum <= DIV_N);
    end

    // Counter and residue update with host-load priority and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
            res_q <= '0;
        end else if (load) begin
            acc_o <= $signed(load_word);
            res_q <= '0;
        end else if (avg_i.stb) begin
            if (carry_up) begin
                res_q <= res_sum - DIV_P;
                if (acc_o != ACC_MAX) acc_o <= acc_o + 1'b1;
            end else if (carry_dn) begin
                res_q <= res_sum + DIV_P;
                if (acc_o != ACC_MIN) acc_o <= acc_o - 1'b1;
            end else begin
                res_q <= res_sum;
            end
        end
    end

    AST_ACC_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((acc_o == $past(acc_o)) || (acc_o == ACC_W'($past(acc_o) + 1'b1))
                   || (acc_o == ACC_W'($past(acc_o) - 1'b1)))); // R5
    AST_RES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (res_q < DIV_P) && (res_q > DIV_N)); // R5
    AST_ACC_CHARGE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && avg_i.stb && !avg_i.val[WORD_W-1]) |=> (acc_o >= $past(acc_o))); // R5
    AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (acc_o == ACC_MAX)) |=> (acc_o != ACC_MIN)); // R6
    AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (acc_o == ACC_MIN)) |=> (acc_o != ACC_MAX)); // R6
    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((acc_o == $signed($past(load_word))) && (res_q == '0))); // R7
endmodule

// File: rtl/bcm_host_port.sv
// Byte-wide host register port. A high-byte read returns the live high byte
// and captures the low byte of the same word, so a later low-byte read is
// coherent with it. Charge-counter writes stage the high byte and commit the
// full word on the low-byte write. Read data is registered.
module bcm_host_port
    import bcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] acc_word,
    output logic [BYTE_W-1:0] rdata,
    output logic              load,
    output logic [WORD_W-1:0] load_word
);
    reg_addr_e         ra;
    logic [BYTE_W-1:0] stage_hi, snap_cur, snap_acc;

    assign ra        = reg_addr_e'(addr);
    assign load      = wr && (ra == RA_ACC_LO);
    assign load_word = {stage_hi, wdata};

    // Stage the high byte of a charge-counter write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          stage_hi <= '0;
        else if (wr && (ra == RA_ACC_HI))    stage_hi <= wdata;
    end

    // Return read data and capture low-byte snapshots on high-byte reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            snap_cur <= '0;
            snap_acc <= '0;
        end else if (rd) begin
            unique case (ra)
                RA_CUR_HI: begin
                    rdata    <= cur_word[WORD_W-1:BYTE_W];
                    snap_cur <= cur_word[BYTE_W-1:0];
                end
                RA_CUR_LO: rdata <= snap_cur;
                RA_ACC_HI: begin
                    rdata    <= acc_word[WORD_W-1:BYTE_W];
                    snap_acc <= acc_word[BYTE_W-1:0];
                end
                RA_ACC_LO: rdata <= snap_acc;
                default:   rdata <= rdata;
            endcase
        end
    end

    AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata)); // R8
    AST_ACC_HI_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (ra == RA_ACC_HI)) |=> (rdata == $past(acc_word[WORD_W-1:BYTE_W]))); // R8
    AST_ACC_LO_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (ra == RA_ACC_LO)) |=> (rdata == $past(snap_acc))); // R8
    AST_CUR_LO_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (ra == RA_CUR_LO)) |=> (rdata == $past(snap_cur))); // R8
endmodule

// File: rtl/batt_current_meter.sv
// Top level: bias-corrected current averaging, fractional charge
// integration and the byte-wide host register port. Sample strobe and the
// millisecond tick come from the analog front end and the time base.
module batt_current_meter
    import bcm_pkg::*;
#(
    parameter int SAMPLE_W   = 13,
    parameter int BIAS_W     = 8,
    parameter int AVG_LOG2   = 7,
    parameter int MS_PER_UPD = 88,
    parameter int RES_DIV    = 16364
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [BIAS_W-1:0]   bias,
    input  logic                ms_tick,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [1:0]          host_addr,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          host_rdata,
    output logic [15:0]         cur_word,
    output logic [15:0]         acc_word
);
    avg_msg_t           avg_msg;
    logic               load;
    logic [WORD_W-1:0]  load_word;
    logic signed [WORD_W-1:0] acc_s;

    assign acc_word = acc_s;

    bcm_avg_window #(
        .SAMPLE_W  (SAMPLE_W),
        .BIAS_W    (BIAS_W),
        .AVG_LOG2  (AVG_LOG2),
        .MS_PER_UPD(MS_PER_UPD)
    ) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .bias     (bias),
        .ms_tick  (ms_tick),
        .cur_word (cur_word),
        .avg_o    (avg_msg)
    );

    bcm_coulomb #(
        .ACC_W  (WORD_W),
        .RES_DIV(RES_DIV)
    ) intg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .avg_i    (avg_msg),
        .load     (load),
        .load_word(load_word),
        .acc_o    (acc_s)
    );

    bcm_host_port port_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (host_rd),
        .wr       (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .cur_word (cur_word),
        .acc_word (acc_word),
        .rdata    (host_rdata),
        .load     (load),
        .load_word(load_word)
    );

    AST_CUR_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cur_word[WORD_W-SAMPLE_W-1:0] == '0)); // R3
endmodule

// File: tb/batt_current_meter_tb.sv
// Bench: behavioural reference model compared on every clock, plus directed
// scenarios with hand-computed expectations.
module batt_current_meter_tb_top;
    localparam int P   = 8;     // ticks per window (tick every cycle)
    localparam int L   = 3;     // average of 8
    localparam int DIV = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [12:0] smp_data = '0;
    logic [7:0]  bias = '0;
    logic        ms_tick = 1'b0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [15:0] cur_word, acc_word;

    int checks = 0, fails = 0, cyc = 0;
    logic [12:0] pv [8];
    int ph = 0;
    bit compare_on = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    batt_current_meter #(.MS_PER_UPD(P), .AVG_LOG2(L), .RES_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .bias(bias), .ms_tick(ms_tick), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cur_word(cur_word), .acc_word(acc_word));

    // ---------------- reference model ----------------
    int m_cur, m_acc, m_res, m_sum, m_cnt, m_pavg, m_stage, m_snapc, m_snapa, m_rdata;
    bit m_pend;

    function automatic int fdiv(int a, int n);
        int q;
        q = a / n;
        if ((a % n != 0) && (a < 0)) q = q - 1;
        return q;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = 0; m_acc = 0; m_res = 0; m_sum = 0; m_cnt = 0; m_pavg = 0;
            m_stage = 0; m_snapc = 0; m_snapa = 0; m_rdata = 0; m_pend = 0;
        end else begin
            int cword, s, b, nsum, q;
            bit ld;
            // host port, using values before this edge
            if (host_rd) begin
                case (host_addr)
                    2'd0: begin m_rdata = (m_cur >> 8) & 255; m_snapc = m_cur & 255; end
                    2'd1: m_rdata = m_snapc;
                    2'd2: begin m_rdata = ((m_acc & 16'hFFFF) >> 8) & 255; m_snapa = m_acc & 255; end
                    default: m_rdata = m_snapa;
                endcase
            end
            ld = host_wr && (host_addr == 2'd3);
            cword = m_stage * 256 + int'(host_wdata);
            if (host_wr && host_addr == 2'd2) m_stage = int'(host_wdata);
            // integrator, using the average published on the previous edge
            if (ld) begin
                m_acc = (cword >= 32768) ? cword - 65536 : cword;
                m_res = 0;
            end else if (m_pend) begin
                m_res = m_res + m_pavg;
                if (m_res >= DIV) begin
                    m_res = m_res - DIV;
                    if (m_acc < 32767) m_acc = m_acc + 1;
                end else if (m_res <= -DIV) begin
                    m_res = m_res + DIV;
                    if (m_acc > -32768) m_acc = m_acc - 1;
                end
            end
            // averaging window
            s = $signed(smp_data);
            b = $signed(bias);
            nsum = m_sum + (smp_valid ? (s - b) : 0);
            m_pend = 0;
            if (ms_tick && m_cnt == P - 1) begin
                q = fdiv(nsum, 1 << L);
                if (q > 4095) q = 4095;
                if (q < -4096) q = -4096;
                m_cur = (q * 8) & 16'hFFFF;
                m_pavg = q;
                m_pend = 1;
                m_sum = 0;
                m_cnt = 0;
            end else begin
                m_sum = nsum;
                if (ms_tick) m_cnt = m_cnt + 1;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model, sampled away from the edge.
    always @(negedge clk) begin
        cyc++;
        if (compare_on) begin
            check("R2 cur_word vs model", cur_word, 16'(m_cur));
            check("R5 acc_word vs model", acc_word, 16'(m_acc & 16'hFFFF));
            check("R8 host_rdata vs model", {8'h00, host_rdata}, 16'(m_rdata));
        end
    end

    task automatic set_const(input logic [12:0] v);
        for (int i = 0; i < 8; i++) pv[i] = v;
    endtask

    task automatic run_cycles(input int n);
        repeat (n) begin
            @(negedge clk);
            smp_data = pv[ph];
            ph = (ph + 1) % 8;
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rb, exp_hi, exp_lo;
        logic [15:0] hold;
        set_const(13'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 cur_word after reset", cur_word, 16'h0000);
        check("R9 acc_word after reset", acc_word, 16'h0000);
        check("R9 host_rdata after reset", {8'h00, host_rdata}, 16'h0000);
        compare_on = 1'b1;
        smp_valid = 1'b1;
        ms_tick = 1'b1;

        // R1/R3: 100 minus bias 20 averages to 80 -> 80<<3 = 0x0280
        set_const(13'd100); bias = 8'd20;
        run_cycles(3 * P);
        check("R1 bias subtracted before averaging", cur_word, 16'h0280);
        check("R3 low three bits zero", {13'h0, cur_word[2:0]}, 16'h0000);

        // R2: floor rounding, sum -5 over 8 -> -1 (0xFFF8); sum +5 -> 0
        bias = 8'd0;
        for (int i = 0; i < 8; i++) pv[i] = (i == 0) ? -13'sd5 : 13'd0;
        run_cycles(3 * P);
        check("R2 floor of negative sum", cur_word, 16'hFFF8);
        for (int i = 0; i < 8; i++) pv[i] = (i == 0) ? 13'd5 : 13'd0;
        run_cycles(3 * P);
        check("R2 floor of small positive sum", cur_word, 16'h0000);

        // R4: clamp high (4095 - (-128)) and low (-4096 - 127)
        set_const(13'd4095); bias = 8'h80;
        run_cycles(3 * P);
        check("R4 clamp at positive limit", cur_word, 16'h7FF8);

        // R5: positive current makes the counter count up from zero
        host_write(2'd2, 8'h00);
        host_write(2'd3, 8'h00);
        run_cycles(10 * P);
        check("R5 charge counter increments on charge", {15'h0, ($signed(acc_word) > 0)}, 16'h0001);

        // R8: high-byte read captures low byte; later low read returns it
        @(negedge clk);
        host_rd = 1'b1; host_addr = 2'd2;
        exp_hi = acc_word[15:8]; exp_lo = acc_word[7:0];
        @(negedge clk);
        host_rd = 1'b0;
        check("R8 high byte live", {8'h00, host_rdata}, {8'h00, exp_hi});
        run_cycles(6 * P);
        host_read(2'd3, rb);
        check("R8 low byte from snapshot", {8'h00, rb}, {8'h00, exp_lo});

        // R7: atomic host load and ignored writes to the current word
        host_write(2'd2, 8'h12);
        host_write(2'd3, 8'h34);
        check("R7 host load of charge counter", acc_word, 16'h1234);
        hold = cur_word;
        host_write(2'd0, 8'hAB);
        host_write(2'd1, 8'hCD);
        check("R7 writes to current word ignored", cur_word, hold);
        host_read(2'd0, rb);
        check("R8 current high byte", {8'h00, rb}, {8'h00, hold[15:8]});
        host_read(2'd1, rb);
        check("R8 current low byte", {8'h00, rb}, {8'h00, hold[7:0]});

        // R6: saturation at the positive limit
        host_write(2'd2, 8'h7F);
        host_write(2'd3, 8'hFF);
        run_cycles(12 * P);
        check("R6 saturate at 0x7FFF", acc_word, 16'h7FFF);

        // R4/R6: clamp low, then saturation at the negative limit
        set_const(13'h1000); bias = 8'h7F;
        run_cycles(3 * P);
        check("R4 clamp at negative limit", cur_word, 16'h8000);
        host_write(2'd2, 8'h80);
        host_write(2'd3, 8'h00);
        run_cycles(12 * P);
        check("R6 saturate at 0x8000", acc_word, 16'h8000);

        // R5: discharge counts down from a loaded value
        host_write(2'd2, 8'h00);
        host_write(2'd3, 8'h10);
        run_cycles(6 * P);
        check("R5 charge counter decrements on discharge", {15'h0, ($signed(acc_word) < 16'sh0010)}, 16'h0001);

        // R9: reset clears everything again
        compare_on = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R9 cur_word after second reset", cur_word, 16'h0000);
        check("R9 acc_word after second reset", acc_word, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule